// File: doc/BRIEF.md
# Conversion Slot Sequencer

This block steps a multi-channel converter through a programmed list of channel codes. The list holds up to sixteen 4-bit slots packed into two 32-bit words. A length field and a sequence-enable bit set how many slots one pass covers. For each slot the sequencer issues one start strobe with the slot's channel code. It then waits for the converter's done handshake before it moves on to the next slot.

Software requests a run with a start pulse and ends a continuous run with a stop pulse. Each request is held in a pending bit, and the sequencer clears that bit itself. In single mode the sequencer returns to idle after one pass. In continuous mode it starts the list again from slot 0 until a stop arrives. When a pass completes, an end-of-pass flag is raised. Software clears it by writing 1, and an enable gates it onto the interrupt line. The analog multiplexer, conversion timing and calibration sit outside this block.

Top module: `conv_seq`

## Requirements
- R1: Slot k (k = 0..7) is read from `list_lo[4k+3:4k]`, and slot k (k = 8..15) is read from `list_hi[4(k-8)+3:4(k-8)]`.
- R2: Each issued slot gives a one-cycle `conv_start` pulse with the slot's code on `conv_chan`. No further `conv_start` is issued until `conv_done` has been seen. Codes 0000-0011 select single-negative inputs, 0100-0111 single-positive inputs, 1000-1011 differential pairs, 1100 the battery and 1101 the temperature sensor.
- R3: A pass covers slots 0 to `seq_len`, which is `seq_len`+1 slots in rising order. When `seq_en` is 0, only slot 0 is converted, whatever `seq_len` holds.
- R4: `start_set` and `stop_set` set the pending bits `start_pend` and `stop_pend`, and hardware clears both. A start pulse sampled at edge E0 leaves `start_pend` high for exactly one cycle. The first `conv_start` appears after edge E0+2.
- R5: With `cont_mode` at 0, the sequencer issues one pass, then `busy` falls and no further conversion starts.
- R6: `eos_flag` is set when the last slot of a pass completes. It is cleared by an `eos_clr` pulse, and a set wins over a clear in the same cycle. `eos_irq` equals `eos_flag` AND `eos_ie`.
- R7: A slot holding a reserved code (1110 or 1111) is skipped without a `conv_start`, but it still counts toward the pass length. A skipped last slot still completes the pass.
- R8: With `cont_mode` at 1, the list repeats from slot 0 after each pass. A stop arriving during a conversion lets that conversion's `conv_done` be taken, then returns to idle without setting `eos_flag`.
- R9: A `start_set` pulse while `busy` is high is ignored: `start_pend` stays 0 and no extra pass follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| list_lo | input | 32 | Slots 0-7, 4 bits each |
| list_hi | input | 32 | Slots 8-15, 4 bits each |
| seq_len | input | 4 | Index of the last slot of a pass |
| seq_en | input | 1 | Sequence enable; 0 limits a pass to slot 0 |
| cont_mode | input | 1 | 1 repeats passes, 0 runs one pass |
| start_set | input | 1 | Software start request pulse |
| stop_set | input | 1 | Software stop request pulse |
| eos_clr | input | 1 | Write-1 clear of the end-of-pass flag |
| eos_ie | input | 1 | End-of-pass interrupt enable |
| conv_done | input | 1 | Converter end-of-conversion handshake |
| conv_start | output | 1 | One-cycle start-conversion strobe |
| conv_chan | output | 4 | Channel code for the current conversion |
| busy | output | 1 | Sequencer is running |
| start_pend | output | 1 | Pending start request |
| stop_pend | output | 1 | Pending stop request |
| eos_flag | output | 1 | End-of-pass flag |
| eos_irq | output | 1 | Gated end-of-pass interrupt |

## Verification
A wrong slot index or last-slot compare shows up at the next `conv_start`. The scoreboard's expected channel order then breaks, or the pass ends with a missing or surplus conversion, so the error appears within one slot time. A fault in the request bits or the stop path shows within a few cycles. The symptoms are a pending bit that stays high, a pass that restarts after a stop, or `eos_flag` set on an aborted pass. Reserved-code handling is visible because a skipped slot must never reach `conv_chan`, while the following slots still arrive in order.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_t;

  // Codes 1110 and 1111 select no input.
  function automatic logic code_reserved(input logic [CODE_W-1:0] c);
    return c[CODE_W-1:1] == 3'b111;
  endfunction
endpackage

// File: rtl/seq_slot_mux.sv
module seq_slot_mux
  import conv_seq_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int REG_W = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [REG_W-1:0]  list_lo,
  input  logic [REG_W-1:0]  list_hi,
  input  logic [IDX_W-1:0]  idx,
  output logic [CODE_W-1:0] code
);
  localparam int PER_REG = REG_W / CODE_W;

  logic [CODE_W-1:0] slot [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < PER_REG) begin : g_lo
      assign slot[g] = list_lo[g*CODE_W +: CODE_W];
    end else begin : g_hi
      assign slot[g] = list_hi[(g-PER_REG)*CODE_W +: CODE_W];
    end
  end

  assign code = slot[idx];
endmodule

// File: rtl/seq_req_bits.sv
module seq_req_bits (
  input  logic clk,
  input  logic rst,
  input  logic start_set,
  input  logic stop_set,
  input  logic eos_clr,
  input  logic is_idle,
  input  logic take_start,
  input  logic drop_stop,
  input  logic eos_hit,
  output logic start_pend,
  output logic stop_pend,
  output logic eos_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      start_pend <= 1'b0;
    end else if (take_start) begin
      start_pend <= 1'b0;
    end else if (start_set && is_idle) begin
      start_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_pend <= 1'b0;
    end else if (drop_stop) begin
      stop_pend <= 1'b0;
    end else if (stop_set) begin
      stop_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eos_flag <= 1'b0;
    end else if (eos_hit) begin
      eos_flag <= 1'b1;
    end else if (eos_clr) begin
      eos_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import conv_seq_pkg::*;
#(
  parameter int SLOTS = 16,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic              cont_mode,
  input  logic              start_pend,
  input  logic              stop_pend,
  input  logic              conv_done,
  output logic [IDX_W-1:0]  idx,
  output seq_state_t        state,
  output logic              conv_start,
  output logic [CODE_W-1:0] conv_chan,
  output logic              take_start,
  output logic              drop_stop,
  output logic              eos_hit
);
  logic is_last;
  logic skip;
  logic slot_end;

  assign is_last  = (idx == last_idx);
  assign skip     = code_reserved(code);
  // A slot ends when its conversion completes or when it is skipped.
  assign slot_end = (state == ST_ISSUE && skip) || (state == ST_WAIT && conv_done);

  assign take_start = (state == ST_IDLE) && start_pend;
  assign drop_stop  = stop_pend && ((state == ST_IDLE) || (state == ST_ISSUE) ||
                                    (state == ST_WAIT && conv_done));
  assign eos_hit    = !stop_pend && is_last && slot_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx        <= '0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
    end else begin
      conv_start <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_pend) begin
            state <= ST_ISSUE;
            idx   <= '0;
          end
        end
        ST_ISSUE: begin
          if (stop_pend) begin
            state <= ST_IDLE;
          end else if (skip) begin
            if (!is_last) begin
              idx <= idx + 1'b1;
            end else if (cont_mode) begin
              idx <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            conv_start <= 1'b1;
            conv_chan  <= code;
            state      <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (conv_done) begin
            if (stop_pend) begin
              state <= ST_IDLE;
            end else if (!is_last) begin
              idx   <= idx + 1'b1;
              state <= ST_ISSUE;
            end else if (cont_mode) begin
              idx   <= '0;
              state <= ST_ISSUE;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_seq_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int REG_W = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  list_lo,
  input  logic [REG_W-1:0]  list_hi,
  input  logic [IDX_W-1:0]  seq_len,
  input  logic              seq_en,
  input  logic              cont_mode,
  input  logic              start_set,
  input  logic              stop_set,
  input  logic              eos_clr,
  input  logic              eos_ie,
  input  logic              conv_done,
  output logic              conv_start,
  output logic [CODE_W-1:0] conv_chan,
  output logic              busy,
  output logic              start_pend,
  output logic              stop_pend,
  output logic              eos_flag,
  output logic              eos_irq
);
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  last_idx;
  logic [CODE_W-1:0] code;
  seq_state_t        state;
  logic              take_start;
  logic              drop_stop;
  logic              eos_hit;

  assign last_idx = seq_en ? seq_len : '0;
  assign busy     = (state != ST_IDLE);
  assign eos_irq  = eos_flag & eos_ie;

  seq_slot_mux #(.SLOTS(SLOTS), .REG_W(REG_W)) slot_mux_i (
    .list_lo (list_lo),
    .list_hi (list_hi),
    .idx     (idx),
    .code    (code)
  );

  seq_fsm #(.SLOTS(SLOTS)) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .code       (code),
    .last_idx   (last_idx),
    .cont_mode  (cont_mode),
    .start_pend (start_pend),
    .stop_pend  (stop_pend),
    .conv_done  (conv_done),
    .idx        (idx),
    .state      (state),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .take_start (take_start),
    .drop_stop  (drop_stop),
    .eos_hit    (eos_hit)
  );

  seq_req_bits req_i (
    .clk        (clk),
    .rst        (rst),
    .start_set  (start_set),
    .stop_set   (stop_set),
    .eos_clr    (eos_clr),
    .is_idle    (!busy),
    .take_start (take_start),
    .drop_stop  (drop_stop),
    .eos_hit    (eos_hit),
    .start_pend (start_pend),
    .stop_pend  (stop_pend),
    .eos_flag   (eos_flag)
  );
endmodule

// File: rtl/conv_seq_checker.sv
module conv_seq_checker (
  input logic       clk,
  input logic       rst,
  input logic       conv_start,
  input logic [3:0] conv_chan,
  input logic       conv_done,
  input logic       busy,
  input logic       start_pend,
  input logic       eos_flag
);
  logic outstanding;

  always_ff @(posedge clk) begin
    if (rst) begin
      outstanding <= 1'b0;
    end else if (conv_start) begin
      outstanding <= 1'b1;
    end else if (conv_done) begin
      outstanding <= 1'b0;
    end
  end

  AST_NO_START_WHILE_PENDING: assert property (@(posedge clk) disable iff (rst)
    outstanding |-> !conv_start); // R2

  AST_NO_RESERVED_ISSUE: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> (conv_chan[3:1] != 3'b111)); // R7

  AST_START_SELF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start_pend |=> !start_pend); // R4

  AST_BUSY_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy); // R5

  AST_EOS_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(eos_flag) |-> $past(busy)); // R6
endmodule

bind conv_seq conv_seq_checker checker_i (
  .clk        (clk),
  .rst        (rst),
  .conv_start (conv_start),
  .conv_chan  (conv_chan),
  .conv_done  (conv_done),
  .busy       (busy),
  .start_pend (start_pend),
  .eos_flag   (eos_flag)
);

// File: tb/conv_seq_tb_top.sv
module conv_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] list_lo = '0;
  logic [31:0] list_hi = '0;
  logic [3:0]  seq_len = '0;
  logic        seq_en = 1'b1;
  logic        cont_mode = 1'b0;
  logic        start_set = 1'b0;
  logic        stop_set = 1'b0;
  logic        eos_clr = 1'b0;
  logic        eos_ie = 1'b0;
  logic        conv_done = 1'b0;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic        busy;
  logic        start_pend;
  logic        stop_pend;
  logic        eos_flag;
  logic        eos_irq;

  int checks = 0;
  int fails  = 0;
  int convs  = 0;
  logic [3:0] exp_q [$];

  always #10 clk = ~clk;

  conv_seq dut_i (
    .clk(clk), .rst(rst), .list_lo(list_lo), .list_hi(list_hi),
    .seq_len(seq_len), .seq_en(seq_en), .cont_mode(cont_mode),
    .start_set(start_set), .stop_set(stop_set), .eos_clr(eos_clr),
    .eos_ie(eos_ie), .conv_done(conv_done), .conv_start(conv_start),
    .conv_chan(conv_chan), .busy(busy), .start_pend(start_pend),
    .stop_pend(stop_pend), .eos_flag(eos_flag), .eos_irq(eos_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Driver side: expected channel order for one pass, from R1, R3, R7.
  task automatic push_pass(input logic [31:0] lo, input logic [31:0] hi, input int last);
    for (int i = 0; i <= last; i++) begin
      logic [3:0] c;
      c = (i < 8) ? lo[i*4 +: 4] : hi[(i-8)*4 +: 4];
      if (c[3:1] != 3'b111) exp_q.push_back(c);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_set = 1'b1;
    @(negedge clk); start_set = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic run_single(input logic [31:0] lo, input logic [31:0] hi,
                            input logic [3:0] len, input logic en);
    list_lo = lo; list_hi = hi; seq_len = len; seq_en = en; cont_mode = 1'b0;
    push_pass(lo, hi, en ? int'(len) : 0);
    pulse_start();
    @(negedge clk);
    wait_idle();
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pops expected codes as strobes appear (R2).
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && conv_start) begin
        convs++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected conversion", int'(conv_chan), -1);
        end else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          check(conv_chan == e, "R2 channel order", int'(conv_chan), int'(e));
        end
      end
    end
  end

  // Converter model: done three cycles after each strobe.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && conv_start) begin
        repeat (3) @(negedge clk);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state
    check(!conv_start, "R2 reset strobe", conv_start, 0);
    check(!busy, "R5 reset busy", busy, 0);
    check(!eos_flag, "R6 reset flag", eos_flag, 0);
    check(!start_pend && !stop_pend, "R4 reset pending", start_pend | stop_pend, 0);

    // Four-slot single pass with start timing
    eos_ie = 1'b1;
    list_lo = 32'h0000_C841; list_hi = '0; seq_len = 4'd3; seq_en = 1'b1;
    push_pass(list_lo, list_hi, 3);
    base = convs;
    @(negedge clk); start_set = 1'b1;
    @(negedge clk); start_set = 1'b0;
    check(start_pend, "R4 pending after start", start_pend, 1);
    @(negedge clk);
    check(!start_pend && !conv_start, "R4 pending cleared", start_pend, 0);
    @(negedge clk);
    check(conv_start, "R4 first strobe at E0+2", conv_start, 1);
    wait_idle();
    repeat (4) @(negedge clk);
    check(convs - base == 4, "R5 single pass count", convs - base, 4);
    check(exp_q.size() == 0, "R3 all slots issued", exp_q.size(), 0);
    check(eos_flag, "R6 flag after pass", eos_flag, 1);
    check(eos_irq, "R6 irq enabled", eos_irq, 1);
    @(negedge clk); eos_clr = 1'b1;
    @(negedge clk); eos_clr = 1'b0;
    check(!eos_flag, "R6 write-1 clear", eos_flag, 0);

    // Sequence disabled: slot 0 only
    base = convs;
    run_single(32'h0076_5432, '0, 4'd5, 1'b0);
    check(convs - base == 1, "R3 seq_en=0 slot 0 only", convs - base, 1);

    // Full sixteen slots across both words
    base = convs;
    run_single(32'h7654_3210, 32'hDCBA_9854, 4'd15, 1'b1);
    check(convs - base == 16, "R1 sixteen slots", convs - base, 16);

    // Reserved codes skipped, last slot reserved; irq gated off
    eos_ie = 1'b0;
    @(negedge clk); eos_clr = 1'b1;
    @(negedge clk); eos_clr = 1'b0;
    base = convs;
    run_single(32'h0000_FDE3, '0, 4'd3, 1'b1);
    check(convs - base == 2, "R7 reserved skipped", convs - base, 2);
    check(eos_flag, "R7 pass ends on skipped slot", eos_flag, 1);
    check(!eos_irq, "R6 irq masked", eos_irq, 0);

    // Start while running is ignored
    list_lo = 32'h0000_0654; seq_len = 4'd2; seq_en = 1'b1; cont_mode = 1'b0;
    push_pass(list_lo, list_hi, 2);
    base = convs;
    pulse_start();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      if (convs > base) break;
    end
    @(negedge clk); start_set = 1'b1;
    @(negedge clk); start_set = 1'b0;
    check(!start_pend, "R9 start ignored while busy", start_pend, 0);
    wait_idle();
    repeat (20) @(negedge clk);
    check(convs - base == 3, "R9 no extra pass", convs - base, 3);
    check(!busy, "R9 idle after pass", busy, 1'b0);

    // Continuous with a stop mid-conversion
    list_lo = 32'h0000_0C21; seq_len = 4'd2; cont_mode = 1'b1;
    for (int p = 0; p < 3; p++) push_pass(list_lo, list_hi, 2);
    base = convs;
    pulse_start();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (convs - base >= 7) break;
    end
    check(eos_flag, "R8 passes repeated", eos_flag, 1);
    @(negedge clk); stop_set = 1'b1; eos_clr = 1'b1;
    @(negedge clk); stop_set = 1'b0; eos_clr = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk);
    check(convs - base == 7, "R8 stop after current", convs - base, 7);
    check(!eos_flag, "R8 no flag on stopped pass", eos_flag, 0);
    check(!stop_pend, "R4 stop self-clears", stop_pend, 0);
    check(exp_q.size() == 2, "R8 remaining expected", exp_q.size(), 2);
    exp_q.delete();

    finish_run();
  end
endmodule